// File: doc/BRIEF.md
# Serial Management Bus Register Target

This block is a bus target for a two-wire serial management bus. Both bus lines are sampled with the system clock. The block finds start and stop conditions and compares the incoming 7-bit device address against its own. After a match it either takes in bytes or returns them. The data line is open-drain: the block never drives it high. It only asserts an output enable that pulls the wire low.

In a write transfer, the first byte after the address loads an internal register pointer. Every later byte is stored at the pointer, and the pointer then steps forward. A read transfer carries no command byte, so it returns bytes starting at whatever pointer an earlier write left behind. A read is normally set up with a pointer-setting write followed by a repeated start.

The top of the map holds four fixed identification registers at 0xF4 to 0xF7, which cannot be written. The system clock must run at roughly eight or more times the bus clock rate. `NUM_REGS` must be a power of two.

Top module: `smb_target`

## Requirements
- R1: While reset is held, and right after it is released, `sda_oe` is 0 (the data line is released).
- R2: A stop condition is SDA rising while SCL is high. It returns the block to idle with SDA released. Bytes clocked after a stop, with no new start, are not acknowledged.
- R3: A start condition is SDA falling while SCL is high. It is followed by a 7-bit address sent MSB first and a direction bit (0 = master writes, 1 = master reads). On a match with `DEV_ADDR`, the block pulls SDA low for the 9th clock and holds it through that clock's high phase.
- R4: When the address does not match, the block gives no acknowledge. It leaves SDA released for every later byte until the next start or stop, and the register pointer is not disturbed.
- R5: In a write transfer, the first byte after the address is loaded into the register pointer. Each following byte is written to the register at the pointer. Every byte of a matched write is acknowledged.
- R6: The pointer increases by one after every data byte written or read. It wraps from 0xFF to 0x00.
- R7: A read transfer returns the byte at the current pointer, MSB first. The block changes its SDA drive during SCL low.
- R8: Addresses 0xF4, 0xF5, 0xF6 and 0xF7 read as 0x41, 0x02, 0x00 and 0x00. A write to any of them is acknowledged and discarded.
- R9: When the master leaves SDA high on the 9th clock of a read byte (not acknowledged), the block stops driving SDA until the next start.
- R10: A start in the middle of any transfer, including inside a byte, restarts address reception.
- R11: The block changes `sda_oe` only while SCL is low.
- R12: Addresses from `NUM_REGS` up to 0xFF that are not identification registers read as 0x00, and writes to them are discarded. Registers below `NUM_REGS` reset to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least about 8x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired value) |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The main function is tried with several patterns:
- **Multi-byte writes followed by pointer-set reads.** These separate correct pointer loading from plain storage, and show auto-increment across a byte boundary.
- **A read of the identification bank and a write attempt into it.** These tell the fixed values apart from ordinary storage.
- **A pointer run from the last writable register into the unimplemented region.** This exposes both the increment and the discard behaviour.
- **A wrong device address, a stop followed by bytes with no start, and a read ended by a not-acknowledge with further clocks.** Each of these must leave SDA released.
- **A repeated start inserted halfway through a data byte.** This shows that address reception restarts instead of the partial byte being stored.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a start
    ST_ADDR,   // shifting in address and direction
    ST_AACK,   // acknowledging the address
    ST_WDAT,   // shifting in a written byte
    ST_WACK,   // acknowledging a written byte
    ST_RDAT,   // shifting out a read byte
    ST_RACK,   // sampling the master's acknowledge
    ST_IGN     // off the bus until start or stop
  } smb_state_e;

  localparam logic [5:0] ID_PAGE = 6'b111101;  // 0xF4..0xF7

  function automatic logic [7:0] id_value(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h41;
      2'd1:    return 8'h02;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] ff_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ff_q   <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      ff_q   <= {ff_q[STAGES-2:0], din};
      prev_q <= ff_q[STAGES-1];
    end
  end

  assign level = ff_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int NUM_REGS = 8,
  parameter int AW       = 8,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  import smb_pkg::*;

  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [AW-1:0] LIMIT = AW'(NUM_REGS);

  logic [DW-1:0] regs [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    assign hit = we && (waddr == AW'(i));
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)  regs[i] <= '0;
      else if (hit) regs[i] <= wdata;
    end
  end

  always_comb begin
    if (raddr < LIMIT)                rdata = regs[raddr[IW-1:0]];
    else if (raddr[7:2] == ID_PAGE)   rdata = DW'(id_value(raddr[1:0]));
    else                              rdata = '0;
  end

  // R8, R12: a write at or above NUM_REGS must leave every stored register unchanged
  for (genvar j = 0; j < NUM_REGS; j++) begin : g_chk
    a_r8_ro_discard: assert property (@(posedge clk) disable iff (!rst_ni)
      (we && waddr >= LIMIT) |=> $stable(regs[j]));
  end

endmodule

// File: rtl/smb_target.sv
module smb_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h34,
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  import smb_pkg::*;

  localparam int AW = 8;
  localparam int CW = 4;
  localparam logic [CW-1:0] FULL = CW'(8);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;

  smb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_scl_sync (
    .clk(clk), .rst_ni(rst_ni), .din(scl_i),
    .level(scl_lvl), .rise(scl_rise), .fall(scl_fall));

  smb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sda_sync (
    .clk(clk), .rst_ni(rst_ni), .din(sda_i),
    .level(sda_lvl), .rise(sda_rise), .fall(sda_fall));

  logic start_ev, stop_ev;
  assign start_ev = scl_lvl & sda_fall;
  assign stop_ev  = scl_lvl & sda_rise;

  smb_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0]    rx_q, rx_d, tx_q, tx_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          first_q, first_d, rw_q, rw_d, mack_q, mack_d, oe_q, oe_d;
  logic          we;
  logic [7:0]    rd_data;

  smb_regfile #(.NUM_REGS(NUM_REGS), .AW(AW), .DW(8)) i_regs (
    .clk(clk), .rst_ni(rst_ni), .we(we), .waddr(ptr_q), .wdata(rx_q),
    .raddr(ptr_q), .rdata(rd_data));

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    ptr_d   = ptr_q;
    first_d = first_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    oe_d    = oe_q;
    we      = 1'b0;
    if (start_ev) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_ev) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (scl_rise) begin
      case (state_q)
        ST_ADDR, ST_WDAT: begin
          rx_d  = {rx_q[6:0], sda_lvl};
          cnt_d = cnt_q + 1'b1;
        end
        ST_RDAT: cnt_d  = cnt_q + 1'b1;
        ST_RACK: mack_d = ~sda_lvl;
        default: ;
      endcase
    end else if (scl_fall) begin
      case (state_q)
        ST_ADDR: if (cnt_q == FULL) begin
          if (rx_q[7:1] == DEV_ADDR) begin
            state_d = ST_AACK;
            oe_d    = 1'b1;
            rw_d    = rx_q[0];
            first_d = 1'b1;
          end else begin
            state_d = ST_IGN;
          end
        end
        ST_AACK: begin
          cnt_d = '0;
          if (rw_q) begin
            state_d = ST_RDAT;
            tx_d    = rd_data;
            oe_d    = ~rd_data[7];
          end else begin
            state_d = ST_WDAT;
            oe_d    = 1'b0;
          end
        end
        ST_WDAT: if (cnt_q == FULL) begin
          state_d = ST_WACK;
          oe_d    = 1'b1;
          if (first_q) begin
            ptr_d   = rx_q;
            first_d = 1'b0;
          end else begin
            we    = 1'b1;
            ptr_d = ptr_q + 1'b1;
          end
        end
        ST_WACK: begin
          state_d = ST_WDAT;
          cnt_d   = '0;
          oe_d    = 1'b0;
        end
        ST_RDAT: begin
          if (cnt_q == FULL) begin
            state_d = ST_RACK;
            oe_d    = 1'b0;
            ptr_d   = ptr_q + 1'b1;
          end else begin
            oe_d = ~tx_q[3'd7 - cnt_q[2:0]];
          end
        end
        ST_RACK: begin
          if (mack_q) begin
            state_d = ST_RDAT;
            cnt_d   = '0;
            tx_d    = rd_data;
            oe_d    = ~rd_data[7];
          end else begin
            state_d = ST_IGN;
          end
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      first_q <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      ptr_q   <= ptr_d;
      first_q <= first_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe = oe_q;

  a_r2_stop_release: assert property (@(posedge clk) disable iff (!rst_ni)
    stop_ev |=> !sda_oe);

  a_r10_start_restart: assert property (@(posedge clk) disable iff (!rst_ni)
    start_ev |=> (state_q == ST_ADDR && cnt_q == '0 && !sda_oe));

  a_r4_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_IGN || state_q == ST_IDLE) |-> !sda_oe);

  a_r11_oe_steady_high: assert property (@(posedge clk) disable iff (!rst_ni)
    (scl_lvl && $past(scl_lvl) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_oe));

endmodule

// File: tb/test_smb_target.sv
module test_smb_target;

  localparam int HP = 16;
  localparam logic [6:0] DEV = 7'h34;
  localparam logic [7:0] ADDR_W = {DEV, 1'b0};
  localparam logic [7:0] ADDR_R = {DEV, 1'b1};

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  logic sda_oe;
  logic sda_bus;

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  smb_target i_smb_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe));

  int checks = 0;
  int errors = 0;
  int    exp_q[$];
  int    obs_q[$];
  string tag_q[$];

  // scoreboard monitor
  always @(negedge clk) begin
    if (obs_q.size() > 0 && exp_q.size() > 0) begin
      int a, e;
      string t;
      a = obs_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (a != e) begin
        errors++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", t, a, e);
      end
    end
  end

  // R11 watcher: sda_oe must not move while SCL stays high
  int   r11_viol = 0;
  logic scl_prev = 1'b1;
  logic oe_prev  = 1'b0;
  always @(negedge clk) begin
    if (rst_n === 1'b1 && scl_m && scl_prev && sda_oe !== oe_prev) r11_viol++;
    scl_prev <= scl_m;
    oe_prev  <= sda_oe;
  end

  task automatic check_now(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    scl_m = 1'b0; tick(HP/2);
    sda_m = 1'b1; tick(HP/2);
    scl_m = 1'b1; tick(HP);
    sda_m = 1'b0; tick(HP);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; tick(HP/2);
    sda_m = 1'b0; tick(HP/2);
    scl_m = 1'b1; tick(HP);
    sda_m = 1'b1; tick(HP);
  endtask

  task automatic bus_bit(input logic b, output logic r);
    scl_m = 1'b0; tick(HP/2);
    sda_m = b;    tick(HP/2);
    scl_m = 1'b1; tick(HP/2);
    r = sda_bus;  tick(HP/2);
  endtask

  task automatic push_exp(input string tag, input int v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // driver: master writes a byte, expects ack level (0 = ack)
  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    logic r;
    push_exp(tag, int'(exp_ack));
    for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
    bus_bit(1'b1, r);
    obs_q.push_back(int'(r));
  endtask

  // driver: master reads a byte, then acks (1) or not (0)
  task automatic recv_byte(input logic [7:0] exp, input logic m_ack, input string tag);
    logic r;
    logic [7:0] v;
    push_exp(tag, int'(exp));
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, r);
      v[i] = r;
    end
    bus_bit(~m_ack, r);
    obs_q.push_back(int'(v));
  endtask

  task automatic set_ptr(input logic [7:0] p);
    bus_start();
    send_byte(ADDR_W, 1'b0, "R3");
    send_byte(p, 1'b0, "R5");
  endtask

  task automatic begin_read();
    bus_start();
    send_byte(ADDR_R, 1'b0, "R3");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic r;
    rst_n = 1'b0;
    scl_m = 1'b1;
    sda_m = 1'b1;
    tick(10);
    check_now("R1 oe in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    tick(10);
    check_now("R1 oe after reset", int'(sda_oe), 0);

    // R5 R6: pointer load then two stored bytes
    set_ptr(8'h02);
    send_byte(8'hA5, 1'b0, "R5");
    send_byte(8'h3C, 1'b0, "R6");
    bus_stop();

    // R7 R10 R9: pointer set, repeated start, read, NACK then silence
    set_ptr(8'h02);
    begin_read();
    recv_byte(8'hA5, 1'b1, "R7");
    recv_byte(8'h3C, 1'b0, "R6");
    recv_byte(8'hFF, 1'b0, "R9");
    bus_stop();

    // R4: wrong address, no ack, next byte ignored, pointer kept at 4
    bus_start();
    send_byte({7'h35, 1'b0}, 1'b1, "R4");
    send_byte(8'h02, 1'b1, "R4");
    bus_stop();
    begin_read();
    recv_byte(8'h00, 1'b0, "R4");
    bus_stop();

    // R8: identification bank
    set_ptr(8'hF4);
    begin_read();
    recv_byte(8'h41, 1'b1, "R8");
    recv_byte(8'h02, 1'b1, "R8");
    recv_byte(8'h00, 1'b1, "R8");
    recv_byte(8'h00, 1'b0, "R8");
    bus_stop();

    // R8: write to ID register acked but discarded
    set_ptr(8'hF4);
    send_byte(8'h99, 1'b0, "R8");
    bus_stop();
    set_ptr(8'hF4);
    begin_read();
    recv_byte(8'h41, 1'b0, "R8");
    bus_stop();

    // R6 R12: run from last register into unimplemented space
    set_ptr(8'h07);
    send_byte(8'h11, 1'b0, "R6");
    send_byte(8'h22, 1'b0, "R12");
    bus_stop();
    set_ptr(8'h07);
    begin_read();
    recv_byte(8'h11, 1'b1, "R6");
    recv_byte(8'h00, 1'b0, "R12");
    bus_stop();

    // R6: wrap from 0xFF to 0x00
    set_ptr(8'hFF);
    begin_read();
    recv_byte(8'h00, 1'b1, "R6");
    recv_byte(8'h00, 1'b0, "R6");
    bus_stop();
    set_ptr(8'h00);
    send_byte(8'h6B, 1'b0, "R5");
    bus_stop();
    set_ptr(8'hFF);
    begin_read();
    recv_byte(8'h00, 1'b1, "R6");
    recv_byte(8'h6B, 1'b0, "R6");
    bus_stop();

    // R10: repeated start inside a data byte
    set_ptr(8'h05);
    send_byte(8'h5A, 1'b0, "R5");
    bus_stop();
    set_ptr(8'h05);
    for (int i = 0; i < 4; i++) bus_bit(1'b1, r);
    begin_read();
    recv_byte(8'h5A, 1'b0, "R10");
    bus_stop();

    // R2: after a stop, bytes without a start are not acknowledged
    bus_start();
    send_byte(ADDR_W, 1'b0, "R3");
    bus_stop();
    send_byte(ADDR_W, 1'b1, "R2");
    check_now("R2 oe idle", int'(sda_oe), 0);
    bus_stop();

    tick(8);
    check_now("R11 oe change during SCL high", r11_viol, 0);
    check_now("R7 scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule